// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor Core

This block is a small stored-program processor built around a single accumulator. It executes a fixed loop of register transfers: fetch an opcode word, fetch an operand-address word, then carry out the operation against a synchronous, word-addressed memory. The memory sits outside the core. The core reaches it only through a memory address register (MAR) and a memory data register (MDR). The data memory and the program memory are the same array, so a program can read and write its own words.

The core holds a program counter (PC), an instruction register (IR), the accumulator (ACC), MAR, MDR and a latched operand address. Zero and negative flags are taken from ACC. A print operation reads a memory word and shows it for one cycle on a strobed output. A single interrupt request is checked only between instructions. When it is taken, the core acknowledges it and redirects the PC to a fixed vector. Halt, an illegal opcode and division by zero each stop the core until the next reset.

Top module: `acc_core`

## Requirements
- R1: While `rst` is high on a clock edge, PC takes `start_addr`, ACC clears to 0 and both `halted` and `err` drop to 0. The first memory read after reset is addressed at `start_addr`.
- R2: Every instruction first reads its opcode word at PC and then advances PC by 1. Every opcode except halt then reads an operand-address word at the new PC and advances PC by 1 again. Halt and illegal opcodes fetch no second word.
- R3: Opcode word values are decimal: load = 50 (ACC gets mem[addr]), add = 40 (ACC gets ACC + mem[addr]), sub = 30 (ACC gets ACC − mem[addr]) and mul = 20 (ACC gets ACC × mem[addr]). Every result is the low 16 bits.
- R4: div = 10 sets ACC to ACC ÷ mem[addr] as signed values, with the quotient truncated toward zero and the low 16 bits kept. A zero divisor leaves ACC unchanged and raises `err` and `halted`.
- R5: store = 60 writes ACC into mem[addr] in a single write cycle and leaves ACC unchanged.
- R6: Branch opcodes 70 to 76 load PC with the operand address. Opcode 70 always branches. Opcodes 71 through 76 branch only when ACC, taken as a signed value, is <0, ≤0, =0, ≠0, ≥0 or >0 respectively. Otherwise execution continues at the next instruction.
- R7: print = 80 reads mem[addr] and raises `print_valid` for exactly one cycle with that word on `print_data`. ACC is left unchanged.
- R8: halt = 0 sets `halted`. After that the core makes no memory access and ignores `irq_req` until reset.
- R9: Any opcode word other than those listed in R3 to R8 sets both `halted` and `err`.
- R10: `irq_req` is checked only at an instruction boundary. When it is taken, `irq_ack` pulses and PC loads `IRQ_VEC`. A request raised during an instruction takes effect only after that instruction has completed.
- R11: `flag_z` is 1 exactly when ACC is 0. `flag_n` equals the sign bit of ACC.
- R12: Read data is consumed one cycle after `mem_rd` is asserted. `mem_rd` and `mem_we` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_addr | input | ADDR_W | PC value loaded on reset |
| mem_addr | output | ADDR_W | Memory address (from MAR) |
| mem_rd | output | 1 | Read request; data is returned on the next cycle |
| mem_we | output | 1 | Write enable |
| mem_wdata | output | DATA_W | Write data (from MDR) |
| mem_rdata | input | DATA_W | Read data, registered in the memory |
| irq_req | input | 1 | Interrupt request |
| irq_ack | output | 1 | One-cycle acknowledge when a request is taken |
| print_valid | output | 1 | Print strobe |
| print_data | output | DATA_W | Word being printed |
| acc_out | output | DATA_W | Current accumulator |
| flag_z | output | 1 | Accumulator is zero |
| flag_n | output | 1 | Accumulator is negative |
| halted | output | 1 | Core has stopped |
| err | output | 1 | Stopped because of an illegal opcode or a zero divisor |

## Verification
The hardest situation to reach from the ports is an interrupt that arrives in the middle of an instruction. The core must finish that instruction before it takes the vector. The bench raises `irq_req` a few cycles after reset, while the first load is still in flight. The vector code adds a constant to ACC and stores the result, so the stored value shows that the load completed before the jump and that the second instruction at the original PC never ran. Branch conditions are swept over signed values at the boundaries, including the most negative and most positive words. The arithmetic operations are swept over every pair from a set of eight corner operands.

// File: rtl/acc_pkg.sv
package acc_pkg;

    // Opcode word values (decimal)
    localparam int OPV_HALT  = 0;
    localparam int OPV_DIV   = 10;
    localparam int OPV_MUL   = 20;
    localparam int OPV_SUB   = 30;
    localparam int OPV_ADD   = 40;
    localparam int OPV_LOAD  = 50;
    localparam int OPV_STORE = 60;
    localparam int OPV_BR    = 70;   // 70..76, low step selects the condition
    localparam int OPV_PRINT = 80;

    typedef enum logic [3:0] {
        K_HALT, K_LOAD, K_STORE, K_ADD, K_SUB, K_MUL, K_DIV,
        K_BRANCH, K_PRINT, K_ILLEGAL
    } kind_e;

    typedef enum logic [2:0] {
        BC_ALWAYS, BC_LT, BC_LE, BC_EQ, BC_NE, BC_GE, BC_GT
    } brcond_e;

    typedef struct packed {
        kind_e   kind;
        brcond_e cond;
    } dec_t;

    typedef enum logic [3:0] {
        S_FMAR,   // boundary: irq check, MAR <- PC
        S_FRD,    // read opcode word
        S_FIR,    // IR <- MDR, PC++
        S_AMAR,   // decode IR, MAR <- PC
        S_ARD,    // read operand-address word
        S_ALAT,   // operand <- MDR, PC++
        S_XMAR,   // branch resolve or MAR <- operand
        S_XRD,    // read operand data
        S_XWR,    // write MDR
        S_XDONE,  // ACC update / print
        S_HALT
    } state_e;

    function automatic logic cond_met(brcond_e c, logic z, logic n);
        case (c)
            BC_ALWAYS: cond_met = 1'b1;
            BC_LT:     cond_met = n;
            BC_LE:     cond_met = n | z;
            BC_EQ:     cond_met = z;
            BC_NE:     cond_met = ~z;
            BC_GE:     cond_met = ~n;
            BC_GT:     cond_met = ~n & ~z;
            default:   cond_met = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/acc_decode.sv
module acc_decode
    import acc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] word,
    output dec_t              dec
);
    localparam int BR_COUNT = 7;

    always_comb begin
        dec.kind = K_ILLEGAL;
        dec.cond = BC_ALWAYS;
        if      (word == DATA_W'(OPV_HALT))  dec.kind = K_HALT;
        else if (word == DATA_W'(OPV_DIV))   dec.kind = K_DIV;
        else if (word == DATA_W'(OPV_MUL))   dec.kind = K_MUL;
        else if (word == DATA_W'(OPV_SUB))   dec.kind = K_SUB;
        else if (word == DATA_W'(OPV_ADD))   dec.kind = K_ADD;
        else if (word == DATA_W'(OPV_LOAD))  dec.kind = K_LOAD;
        else if (word == DATA_W'(OPV_STORE)) dec.kind = K_STORE;
        else if (word == DATA_W'(OPV_PRINT)) dec.kind = K_PRINT;
        else begin
            for (int i = 0; i < BR_COUNT; i++) begin
                if (word == DATA_W'(OPV_BR + i)) begin
                    dec.kind = K_BRANCH;
                    dec.cond = brcond_e'(i);
                end
            end
        end
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  kind_e             kind,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y,
    output logic              div_zero
);
    localparam logic [DATA_W-1:0] ALL_ONES = '1;

    logic [2*DATA_W-1:0] prod;
    logic [DATA_W-1:0]   quot;

    assign prod = a * b;

    always_comb begin
        quot = '0;
        if (b == '0)
            quot = '0;
        else if (b == ALL_ONES)
            quot = DATA_W'(-a);
        else
            quot = DATA_W'($signed(a) / $signed(b));
    end

    always_comb begin
        div_zero = 1'b0;
        case (kind)
            K_LOAD:  y = b;
            K_ADD:   y = a + b;
            K_SUB:   y = a - b;
            K_MUL:   y = prod[DATA_W-1:0];
            K_DIV: begin
                y        = quot;
                div_zero = (b == '0);
            end
            default: y = a;
        endcase
    end
endmodule

// File: rtl/acc_seq.sv
module acc_seq
    import acc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  kind_e  kind,
    input  logic   irq_req,
    input  logic   div_zero,
    output state_e state
);
    state_e nxt;

    always_comb begin
        nxt = state;
        case (state)
            S_FMAR:  nxt = irq_req ? S_FMAR : S_FRD;
            S_FRD:   nxt = S_FIR;
            S_FIR:   nxt = S_AMAR;
            S_AMAR:  nxt = (kind == K_HALT || kind == K_ILLEGAL) ? S_HALT : S_ARD;
            S_ARD:   nxt = S_ALAT;
            S_ALAT:  nxt = S_XMAR;
            S_XMAR: begin
                if (kind == K_BRANCH)     nxt = S_FMAR;
                else if (kind == K_STORE) nxt = S_XWR;
                else                      nxt = S_XRD;
            end
            S_XRD:   nxt = S_XDONE;
            S_XWR:   nxt = S_FMAR;
            S_XDONE: nxt = (kind == K_DIV && div_zero) ? S_HALT : S_FMAR;
            S_HALT:  nxt = S_HALT;
            default: nxt = S_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= S_FMAR;
        else     state <= nxt;
    end
endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_pkg::*;
#(
    parameter int                DATA_W  = 16,
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] IRQ_VEC = 8'hC0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              irq_req,
    output logic              irq_ack,
    output logic              print_valid,
    output logic [DATA_W-1:0] print_data,
    output logic [DATA_W-1:0] acc_out,
    output logic              flag_z,
    output logic              flag_n,
    output logic              halted,
    output logic              err
);
    localparam int SIGN = DATA_W - 1;

    logic [ADDR_W-1:0] pc, mar, opnd;
    logic [DATA_W-1:0] ir, mdr, acc, alu_y;
    logic              err_q, div_zero, taken;
    dec_t              dec;
    state_e            state;

    acc_decode #(.DATA_W(DATA_W)) u_dec (
        .word (ir),
        .dec  (dec)
    );

    acc_alu #(.DATA_W(DATA_W)) u_alu (
        .kind     (dec.kind),
        .a        (acc),
        .b        (mem_rdata),
        .y        (alu_y),
        .div_zero (div_zero)
    );

    acc_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .kind     (dec.kind),
        .irq_req  (irq_req),
        .div_zero (div_zero),
        .state    (state)
    );

    assign flag_z = (acc == '0);
    assign flag_n = acc[SIGN];
    assign taken  = cond_met(dec.cond, flag_z, flag_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc    <= start_addr;
            mar   <= '0;
            opnd  <= '0;
            ir    <= '0;
            mdr   <= '0;
            acc   <= '0;
            err_q <= 1'b0;
        end else begin
            case (state)
                S_FMAR: begin
                    if (irq_req) pc <= IRQ_VEC;
                    else         mar <= pc;
                end
                S_FIR: begin
                    ir  <= mem_rdata;
                    mdr <= mem_rdata;
                    pc  <= pc + 1'b1;
                end
                S_AMAR: begin
                    mar <= pc;
                    if (dec.kind == K_ILLEGAL) err_q <= 1'b1;
                end
                S_ALAT: begin
                    opnd <= mem_rdata[ADDR_W-1:0];
                    mdr  <= mem_rdata;
                    pc   <= pc + 1'b1;
                end
                S_XMAR: begin
                    if (dec.kind == K_BRANCH) begin
                        if (taken) pc <= opnd;
                    end else begin
                        mar <= opnd;
                        if (dec.kind == K_STORE) mdr <= acc;
                    end
                end
                S_XDONE: begin
                    mdr <= mem_rdata;
                    case (dec.kind)
                        K_LOAD, K_ADD, K_SUB, K_MUL: acc <= alu_y;
                        K_DIV: begin
                            if (div_zero) err_q <= 1'b1;
                            else          acc   <= alu_y;
                        end
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    assign mem_addr    = mar;
    assign mem_rd      = (state == S_FRD) || (state == S_ARD) || (state == S_XRD);
    assign mem_we      = (state == S_XWR);
    assign mem_wdata   = mdr;
    assign irq_ack     = (state == S_FMAR) && irq_req;
    assign print_valid = (state == S_XDONE) && (dec.kind == K_PRINT);
    assign print_data  = mem_rdata;
    assign acc_out     = acc;
    assign halted      = (state == S_HALT);
    assign err         = err_q;
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_rd,
    input logic              mem_we,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [DATA_W-1:0] acc_out,
    input logic              print_valid,
    input logic              halted,
    input logic              err,
    input logic              irq_req,
    input logic              irq_ack
);
    a_r5_store_data: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_wdata == acc_out));

    a_r5_store_keeps_acc: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> $stable(acc_out));

    a_r7_print_pulse: assert property (@(posedge clk) disable iff (rst)
        print_valid |=> !print_valid);

    a_r8_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    a_r8_halt_quiet: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!mem_rd && !mem_we && !irq_ack));

    a_r9_err_halts: assert property (@(posedge clk) disable iff (rst)
        err |-> halted);

    a_r10_ack_needs_req: assert property (@(posedge clk) disable iff (rst)
        irq_ack |-> irq_req);

    a_r12_no_rd_wr: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_we));
endmodule

bind acc_core acc_core_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mem_rd      (mem_rd),
    .mem_we      (mem_we),
    .mem_wdata   (mem_wdata),
    .acc_out     (acc_out),
    .print_valid (print_valid),
    .halted      (halted),
    .err         (err),
    .irq_req     (irq_req),
    .irq_ack     (irq_ack)
);

// File: tb/sim_acc_core.sv
module sim_acc_core;
    localparam int DW = 16;
    localparam int AW = 8;
    localparam logic [AW-1:0] START = 8'h20;
    localparam logic [AW-1:0] VEC   = 8'hC0;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] start_addr = START;
    logic [AW-1:0] mem_addr;
    logic          mem_rd, mem_we;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          irq_req = 1'b0;
    logic          irq_ack, print_valid, flag_z, flag_n, halted, err;
    logic [DW-1:0] print_data, acc_out;

    logic [DW-1:0] mem [256];

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    int            rd_cnt, we_cnt, pr_cnt, ack_cnt;
    logic [AW-1:0] rd_log [16];
    logic [DW-1:0] pr_last;

    always #10 clk = ~clk;

    acc_core #(.DATA_W(DW), .ADDR_W(AW), .IRQ_VEC(VEC)) u0 (
        .clk(clk), .rst(rst), .start_addr(start_addr),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .irq_req(irq_req), .irq_ack(irq_ack),
        .print_valid(print_valid), .print_data(print_data),
        .acc_out(acc_out), .flag_z(flag_z), .flag_n(flag_n),
        .halted(halted), .err(err)
    );

    // memory model: registered read, one-cycle latency
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    // port monitor, sampled at the falling edge
    always @(negedge clk) begin
        if (rst) begin
            rd_cnt = 0; we_cnt = 0; pr_cnt = 0; ack_cnt = 0; pr_last = '0;
        end else begin
            if (mem_rd) begin
                if (rd_cnt < 16) rd_log[rd_cnt] = mem_addr;
                rd_cnt++;
            end
            if (mem_we) we_cnt++;
            if (print_valid) begin pr_cnt++; pr_last = print_data; end
            if (irq_ack) ack_cnt++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            errors++;
            $display("FAIL watchdog: actual cycles=%0d expected < 190000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 16'hBEEF;
    endtask

    task automatic put(input int a, input int v);
        mem[a] = v[DW-1:0];
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_halt(input string req);
        int n = 0;
        while (!halted && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(req, {31'd0, halted}, 32'd1);
    endtask

    function automatic logic [DW-1:0] expect_op(input int op, input logic [DW-1:0] a, input logic [DW-1:0] b);
        int x, y;
        x = $signed(a);
        y = $signed(b);
        case (op)
            40: expect_op = a + b;
            30: expect_op = a - b;
            20: expect_op = DW'(x * y);
            default: expect_op = DW'(x / y);
        endcase
    endfunction

    logic [DW-1:0] vals [8];

    initial begin
        vals[0] = 16'd0;    vals[1] = 16'd1;    vals[2] = 16'hFFFF; vals[3] = 16'd7;
        vals[4] = 16'hFFF7; vals[5] = 16'd300;  vals[6] = 16'h8000; vals[7] = 16'h7FFF;

        // R1: reset state with a previously nonzero accumulator
        clear_mem();
        put(1, 16'h55); put(32, 50); put(33, 1); put(34, 0);
        do_reset();
        wait_halt("R8");
        chk("R3 load", acc_out, 32'h55);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1 acc cleared", acc_out, 32'd0);
        chk("R1 halted cleared", {31'd0, halted}, 32'd0);
        chk("R1 err cleared", {31'd0, err}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1 first read at start", {24'd0, rd_log[0]}, {24'd0, START});

        // R2 / R3 / R4 / R11: sweep over all operand pairs
        for (int opi = 0; opi < 4; opi++) begin
            int op;
            op = (opi == 0) ? 40 : (opi == 1) ? 30 : (opi == 2) ? 20 : 10;
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    logic [DW-1:0] e;
                    if (!(op == 10 && vals[j] == 0)) begin
                        clear_mem();
                        put(1, vals[i]); put(2, vals[j]);
                        put(32, 50); put(33, 1);
                        put(34, op); put(35, 2);
                        put(36, 60); put(37, 3);
                        put(38, 0);
                        do_reset();
                        wait_halt("R8");
                        e = expect_op(op, vals[i], vals[j]);
                        if (op == 10) chk("R4 div result", mem[3], e);
                        else          chk("R3 arith result", mem[3], e);
                        chk("R5 acc after store", acc_out, e);
                        chk("R11 zero flag", {31'd0, flag_z}, {31'd0, e == 0});
                        chk("R11 neg flag", {31'd0, flag_n}, {31'd0, e[DW-1]});
                        if (opi == 0 && i == 3 && j == 5) begin
                            // R2: read address sequence, halt reads one word only
                            chk("R2 read count", rd_cnt, 32'd9);
                            chk("R2 rd0", rd_log[0], 32'h20);
                            chk("R2 rd1", rd_log[1], 32'h21);
                            chk("R2 rd2", rd_log[2], 32'h01);
                            chk("R2 rd3", rd_log[3], 32'h22);
                            chk("R2 rd4", rd_log[4], 32'h23);
                            chk("R2 rd5", rd_log[5], 32'h02);
                            chk("R2 rd6", rd_log[6], 32'h24);
                            chk("R2 rd7", rd_log[7], 32'h25);
                            chk("R2 rd8 halt", rd_log[8], 32'h26);
                            chk("R5 single write", we_cnt, 32'd1);
                            chk("R9 no err", {31'd0, err}, 32'd0);
                        end
                    end
                end
            end
        end

        // R6: every branch condition over signed corner values
        for (int c = 0; c < 7; c++) begin
            for (int i = 0; i < 8; i++) begin
                logic tk;
                int   v;
                v = $signed(vals[i]);
                case (c)
                    0: tk = 1'b1;
                    1: tk = v < 0;
                    2: tk = v <= 0;
                    3: tk = v == 0;
                    4: tk = v != 0;
                    5: tk = v >= 0;
                    default: tk = v > 0;
                endcase
                clear_mem();
                put(1, vals[i]); put(2, 111); put(4, 222);
                put(32, 50); put(33, 1);
                put(34, 70 + c); put(35, 48);
                put(36, 50); put(37, 2); put(38, 60); put(39, 3); put(40, 0);
                put(48, 50); put(49, 4); put(50, 60); put(51, 3); put(52, 0);
                do_reset();
                wait_halt("R8");
                chk("R6 branch outcome", mem[3], tk ? 32'd222 : 32'd111);
            end
        end

        // R7: print strobe
        clear_mem();
        put(7, 16'h1234);
        put(32, 80); put(33, 7); put(34, 0);
        do_reset();
        wait_halt("R8");
        chk("R7 print count", pr_cnt, 32'd1);
        chk("R7 print data", pr_last, 32'h1234);
        chk("R7 acc unchanged", acc_out, 32'd0);

        // R8: halted core stays quiet and ignores irq
        rd_cnt = 0; we_cnt = 0;
        irq_req = 1'b1;
        repeat (20) @(negedge clk);
        irq_req = 1'b0;
        chk("R8 no reads after halt", rd_cnt, 32'd0);
        chk("R8 no writes after halt", we_cnt, 32'd0);
        chk("R8 irq ignored", ack_cnt, 32'd0);
        chk("R8 still halted", {31'd0, halted}, 32'd1);

        // R9: illegal opcode
        clear_mem();
        put(32, 99);
        do_reset();
        wait_halt("R9 halts");
        chk("R9 err set", {31'd0, err}, 32'd1);
        chk("R9 one read only", rd_cnt, 32'd1);

        // R4: divide by zero
        clear_mem();
        put(1, 50); put(2, 0);
        put(32, 50); put(33, 1); put(34, 10); put(35, 2);
        put(36, 60); put(37, 3); put(38, 0);
        do_reset();
        wait_halt("R4 halts");
        chk("R4 err on zero divisor", {31'd0, err}, 32'd1);
        chk("R4 acc kept", acc_out, 32'd50);
        chk("R4 store skipped", mem[3], 32'hBEEF);

        // R10: interrupt raised in the middle of the first instruction
        clear_mem();
        put(1, 5); put(2, 6); put(4, 100);
        put(32, 50); put(33, 1); put(34, 40); put(35, 2);
        put(36, 60); put(37, 5); put(38, 0);
        put(192, 40); put(193, 4); put(194, 60); put(195, 5); put(196, 0);
        do_reset();
        repeat (3) @(negedge clk);
        irq_req = 1'b1;
        begin
            int n = 0;
            while (!irq_ack && n < 100) begin @(negedge clk); n++; end
        end
        @(negedge clk);
        irq_req = 1'b0;
        wait_halt("R10 halts");
        chk("R10 ack once", ack_cnt, 32'd1);
        chk("R10 load done before vector", mem[5], 32'd105);
        chk("R10 second instruction skipped", acc_out, 32'd105);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule